// File: doc/BRIEF.md
# Indexed Performance Counter Bank

A core-side bank of 64-bit event counters reached through a narrow auxiliary register window. One index register picks which counter the per-counter registers (count, limit, configuration) refer to. Each counter, when enabled, follows one event strobe chosen from a small event vector. It counts upward from whatever value software last wrote.

Each counter also holds a 64-bit limit. On the cycle its incrementing count becomes equal to that limit, it raises a private active flag, provided its interrupt-enable bit is set. Counting carries on afterwards. The flags are ORed into a single interrupt line. Software clears the flags by writing ones to the active register, and the line drops only once every raised flag has been cleared. A control register gives two global actions: zero all counts, and copy every count into a shadow copy. Count reads always return the shadow copy.

Top module: `pctr_bank`

## Requirements
- R1: After reset every count, shadow, limit, configuration, index, enable and active bit is zero, and `irq_o` is low.
- R2: Configuration register (0x254): bit 0 enables counting, and bits starting at bit 8 select the event input. An enabled counter adds one on each clock edge where its selected `evt_in` bit is high, starting from the value written to count low (0x250) and count high (0x251). The low word carries into the high word.
- R3: Writing control (0x255) with bit 17 set copies every counter into its shadow in one cycle. Count reads return the shadow, which stays unchanged until the next snapshot.
- R4: Writing control with bit 16 set zeroes every count. If bit 17 is set in the same write, the snapshot captures the values from before the clear.
- R5: A counter's active flag sets on the edge where its count steps to equal its 64-bit limit (0x25C low, 0x25D high), and the count keeps advancing afterwards.
- R6: No flag sets for a counter whose bit in interrupt-enable (0x25E, one bit per counter) is clear.
- R7: `irq_o` is high while any bit of interrupt-active (0x25F) is high. Writing 1 to an active bit clears only that bit, so the line stays high until every raised bit has been cleared.
- R8: If a limit match and a write-one clear of the same flag happen on the same edge, the flag stays set.
- R9: The index register is at 0x256. While it holds a value at or above the counter count, reads of count, limit and configuration return 0, and writes to them change no counter.
- R10: The read-only capability word at 0x252 holds a version in bits 7:0, 0 in bits 9:8, 1 in bit 10 (interrupts supported), 0 in bits 15:11, the counter count in bits 23:16, and the counter width in bits 31:24.
- R11: A software write to count low or count high takes priority over an increment on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| aux_we | input | 1 | Register write strobe |
| aux_addr | input | 12 | Register address, used for both reads and writes |
| aux_wdata | input | 32 | Write data |
| aux_rdata | output | 32 | Read data for `aux_addr`, combinational |
| evt_in | input | NUM_EVT | Event strobes, one cycle per event |
| irq_o | output | 1 | OR of all active flags |

## Verification
The checker assumes two things about the inputs. Write strobes are the only path that clears a flag, and a flag can rise only on a cycle where some event strobe was high. So it requires that `evt_in` and `aux_we` are driven synchronously, with no glitches at the edge. The bench drives all inputs on the falling edge and samples there. It keeps events quiet during register set-up, so counts change only in the windows it measures. Random event patterns run against random 64-bit start values, including starts just below a low-word carry, and against limits that may or may not be reached.

// File: rtl/pctr_pkg.sv
package pctr_pkg;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 2 * DATA_W;
    localparam int IDX_W  = 8;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] A_CNT_LO = 12'h250;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 12'h251;
    localparam logic [ADDR_W-1:0] A_BUILD  = 12'h252;
    localparam logic [ADDR_W-1:0] A_CFG    = 12'h254;
    localparam logic [ADDR_W-1:0] A_CTRL   = 12'h255;
    localparam logic [ADDR_W-1:0] A_IDX    = 12'h256;
    localparam logic [ADDR_W-1:0] A_LIM_LO = 12'h25C;
    localparam logic [ADDR_W-1:0] A_LIM_HI = 12'h25D;
    localparam logic [ADDR_W-1:0] A_INTEN  = 12'h25E;
    localparam logic [ADDR_W-1:0] A_ACT    = 12'h25F;

    localparam int CTL_CLR_BIT  = 16;
    localparam int CTL_SNAP_BIT = 17;
    localparam int CFG_SEL_LSB  = 8;
endpackage

// File: rtl/pctr_slot.sv
module pctr_slot
    import pctr_pkg::*;
#(
    parameter int NUM_EVT = 4,
    localparam int SEL_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EVT-1:0] evt_in,
    input  logic              wr_cnt_lo,
    input  logic              wr_cnt_hi,
    input  logic              wr_lim_lo,
    input  logic              wr_lim_hi,
    input  logic              wr_cfg,
    input  logic [DATA_W-1:0] wdata,
    input  logic              clr_all,
    input  logic              snap,
    input  logic              int_en,
    input  logic              ack,
    output logic [CNT_W-1:0]  shadow,
    output logic [CNT_W-1:0]  limit,
    output logic [DATA_W-1:0] cfg,
    output logic              flag
);
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_nx;
    logic             run_q;
    logic [SEL_W-1:0] sel_q;
    logic             evt_hit;
    logic             bump;
    logic             hit;

    always_comb begin
        evt_hit = 1'b0;
        for (int e = 0; e < NUM_EVT; e++)
            if (sel_q == SEL_W'(e)) evt_hit = evt_in[e];
    end

    assign bump     = run_q && evt_hit && !clr_all && !wr_cnt_lo && !wr_cnt_hi;
    assign count_nx = count_q + CNT_W'(1);
    assign hit      = bump && (count_nx == limit);
    assign cfg      = DATA_W'(run_q) | (DATA_W'(sel_q) << CFG_SEL_LSB);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clr_all) begin
            count_q <= '0;
        end else if (wr_cnt_lo || wr_cnt_hi) begin
            if (wr_cnt_lo) count_q[DATA_W-1:0]     <= wdata;
            if (wr_cnt_hi) count_q[CNT_W-1:DATA_W] <= wdata;
        end else if (bump) begin
            count_q <= count_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= '0;
        end else if (snap) begin
            shadow <= count_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            limit <= '0;
            run_q <= 1'b0;
            sel_q <= '0;
        end else begin
            if (wr_lim_lo) limit[DATA_W-1:0]     <= wdata;
            if (wr_lim_hi) limit[CNT_W-1:DATA_W] <= wdata;
            if (wr_cfg) begin
                run_q <= wdata[0];
                sel_q <= wdata[CFG_SEL_LSB +: SEL_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (hit && int_en) begin
            flag <= 1'b1;
        end else if (ack) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/pctr_rdmux.sv
module pctr_rdmux
    import pctr_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter logic [7:0] VERSION = 8'h01
) (
    input  logic [ADDR_W-1:0]             addr,
    input  logic [IDX_W-1:0]              idx,
    input  logic [NUM_CTR-1:0][CNT_W-1:0] shadow,
    input  logic [NUM_CTR-1:0][CNT_W-1:0] limit,
    input  logic [NUM_CTR-1:0][DATA_W-1:0] cfg,
    input  logic [NUM_CTR-1:0]            inten,
    input  logic [NUM_CTR-1:0]            active,
    output logic [DATA_W-1:0]             rdata
);
    logic [CNT_W-1:0]  sh_sel;
    logic [CNT_W-1:0]  lim_sel;
    logic [DATA_W-1:0] cfg_sel;
    logic [DATA_W-1:0] build_w;

    assign build_w = {8'(CNT_W), 8'(NUM_CTR), 5'd0, 1'b1, 2'd0, VERSION};

    always_comb begin
        sh_sel  = '0;
        lim_sel = '0;
        cfg_sel = '0;
        for (int i = 0; i < NUM_CTR; i++) begin
            if (idx == IDX_W'(i)) begin
                sh_sel  = shadow[i];
                lim_sel = limit[i];
                cfg_sel = cfg[i];
            end
        end
    end

    always_comb begin
        unique case (addr)
            A_CNT_LO: rdata = sh_sel[DATA_W-1:0];
            A_CNT_HI: rdata = sh_sel[CNT_W-1:DATA_W];
            A_BUILD:  rdata = build_w;
            A_CFG:    rdata = cfg_sel;
            A_IDX:    rdata = DATA_W'(idx);
            A_LIM_LO: rdata = lim_sel[DATA_W-1:0];
            A_LIM_HI: rdata = lim_sel[CNT_W-1:DATA_W];
            A_INTEN:  rdata = DATA_W'(inten);
            A_ACT:    rdata = DATA_W'(active);
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/pctr_bank.sv
module pctr_bank
    import pctr_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int NUM_EVT = 4,
    parameter logic [7:0] VERSION = 8'h01
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               aux_we,
    input  logic [ADDR_W-1:0]  aux_addr,
    input  logic [DATA_W-1:0]  aux_wdata,
    output logic [DATA_W-1:0]  aux_rdata,
    input  logic [NUM_EVT-1:0] evt_in,
    output logic               irq_o
);
    logic [IDX_W-1:0]               idx_q;
    logic [NUM_CTR-1:0]             inten_q;
    logic [NUM_CTR-1:0]             flags;
    logic [NUM_CTR-1:0]             ack_vec;
    logic [NUM_CTR-1:0][CNT_W-1:0]  shadow_bus;
    logic [NUM_CTR-1:0][CNT_W-1:0]  limit_bus;
    logic [NUM_CTR-1:0][DATA_W-1:0] cfg_bus;
    logic                           clr_all;
    logic                           snap;
    logic                           ctl_we;
    logic                           act_we;

    assign ctl_we  = aux_we && (aux_addr == A_CTRL);
    assign act_we  = aux_we && (aux_addr == A_ACT);
    assign clr_all = ctl_we && aux_wdata[CTL_CLR_BIT];
    assign snap    = ctl_we && aux_wdata[CTL_SNAP_BIT];
    assign ack_vec = act_we ? aux_wdata[NUM_CTR-1:0] : '0;
    assign irq_o   = |flags;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            inten_q <= '0;
        end else if (aux_we) begin
            if (aux_addr == A_IDX)   idx_q   <= aux_wdata[IDX_W-1:0];
            if (aux_addr == A_INTEN) inten_q <= aux_wdata[NUM_CTR-1:0];
        end
    end

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_slot
        logic here;
        assign here = aux_we && (idx_q == IDX_W'(g));

        pctr_slot #(.NUM_EVT(NUM_EVT)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt_in    (evt_in),
            .wr_cnt_lo (here && aux_addr == A_CNT_LO),
            .wr_cnt_hi (here && aux_addr == A_CNT_HI),
            .wr_lim_lo (here && aux_addr == A_LIM_LO),
            .wr_lim_hi (here && aux_addr == A_LIM_HI),
            .wr_cfg    (here && aux_addr == A_CFG),
            .wdata     (aux_wdata),
            .clr_all   (clr_all),
            .snap      (snap),
            .int_en    (inten_q[g]),
            .ack       (ack_vec[g]),
            .shadow    (shadow_bus[g]),
            .limit     (limit_bus[g]),
            .cfg       (cfg_bus[g]),
            .flag      (flags[g])
        );
    end

    pctr_rdmux #(.NUM_CTR(NUM_CTR), .VERSION(VERSION)) u_rdmux (
        .addr   (aux_addr),
        .idx    (idx_q),
        .shadow (shadow_bus),
        .limit  (limit_bus),
        .cfg    (cfg_bus),
        .inten  (inten_q),
        .active (flags),
        .rdata  (aux_rdata)
    );
endmodule

// File: rtl/pctr_bank_chk.sv
module pctr_bank_chk
    import pctr_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int NUM_EVT = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          aux_we,
    input logic [ADDR_W-1:0]             aux_addr,
    input logic [DATA_W-1:0]             aux_wdata,
    input logic [NUM_EVT-1:0]            evt_in,
    input logic                          irq_o,
    input logic [NUM_CTR-1:0]            flags,
    input logic [NUM_CTR-1:0]            inten,
    input logic                          snap,
    input logic [NUM_CTR-1:0][CNT_W-1:0] shadow_bus
);
    // R7
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> $past(aux_we && aux_addr == A_ACT));

    // R3
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(snap) |-> $stable(shadow_bus));

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_chk
        // R6
        flag_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flags[i]) |-> $past(inten[i]));

        // R5
        flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flags[i]) |-> $past(|evt_in));

        // R7
        flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flags[i]) |-> $past(aux_we && aux_addr == A_ACT && aux_wdata[i]));
    end
endmodule

bind pctr_bank pctr_bank_chk #(.NUM_CTR(NUM_CTR), .NUM_EVT(NUM_EVT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .aux_we     (aux_we),
    .aux_addr   (aux_addr),
    .aux_wdata  (aux_wdata),
    .evt_in     (evt_in),
    .irq_o      (irq_o),
    .flags      (flags),
    .inten      (inten_q),
    .snap       (snap),
    .shadow_bus (shadow_bus)
);

// File: tb/pctr_bank_tb.sv
module pctr_bank_tb;
    import pctr_pkg::*;

    localparam int NC = 4;
    localparam int NE = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              aux_we = 1'b0;
    logic [ADDR_W-1:0] aux_addr = '0;
    logic [DATA_W-1:0] aux_wdata = '0;
    logic [DATA_W-1:0] aux_rdata;
    logic [NE-1:0]     evt_in = '0;
    logic              irq_o;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    pctr_bank #(.NUM_CTR(NC), .NUM_EVT(NE), .VERSION(8'h01)) u_dut (
        .clk(clk), .rst_n(rst_n), .aux_we(aux_we), .aux_addr(aux_addr),
        .aux_wdata(aux_wdata), .aux_rdata(aux_rdata), .evt_in(evt_in), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_ev(input logic [ADDR_W-1:0] a, input logic [31:0] d, input logic [NE-1:0] ev);
        @(negedge clk);
        aux_we = 1'b1; aux_addr = a; aux_wdata = d; evt_in = ev;
        @(negedge clk);
        aux_we = 1'b0; evt_in = '0;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        wr_ev(a, d, '0);
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        aux_addr = a;
        #1;
        d = aux_rdata;
    endtask

    task automatic pulse(input logic [NE-1:0] ev, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            evt_in = ev;
        end
        @(negedge clk);
        evt_in = '0;
    endtask

    function automatic logic [31:0] cfg_word(input int sel);
        return 32'(1) | (32'(sel) << 8);
    endfunction

    function automatic logic [31:0] build_word(input int nc);
        return {8'd64, 8'(nc), 5'd0, 1'b1, 2'd0, 8'h01};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [63:0] start, lim, expc;
        void'($urandom(32'd2718));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_ACT, r);    chk("R1 active", r, 0);
        chk("R1 irq", 32'(irq_o), 0);
        rd(A_IDX, r);    chk("R1 index", r, 0);
        rd(A_CNT_LO, r); chk("R1 count", r, 0);
        rd(A_LIM_LO, r); chk("R1 limit", r, 0);
        rd(A_INTEN, r);  chk("R1 inten", r, 0);

        // R10 capability word
        rd(A_BUILD, r);  chk("R10 build", r, build_word(NC));

        // R2 counting from written start on selected event
        wr(A_IDX, 1);
        wr(A_CFG, cfg_word(2));
        rd(A_CFG, r);    chk("R2 cfg readback", r, cfg_word(2));
        wr(A_CNT_LO, 100);
        wr(A_CNT_HI, 0);
        pulse(4'b0100, 5);
        pulse(4'b0001, 3);
        wr(A_CTRL, 32'h0002_0000);
        rd(A_CNT_LO, r); chk("R2 count", r, 105);

        // R3 shadow holds until next snapshot
        pulse(4'b0100, 3);
        rd(A_CNT_LO, r); chk("R3 shadow held", r, 105);
        wr(A_CTRL, 32'h0002_0000);
        rd(A_CNT_LO, r); chk("R3 new snapshot", r, 108);

        // R11 write wins over increment
        wr_ev(A_CNT_LO, 50, 4'b0100);
        wr(A_CTRL, 32'h0002_0000);
        rd(A_CNT_LO, r); chk("R11 write priority", r, 50);

        // R4 clear with snapshot captures pre-clear value
        wr(A_CTRL, 32'h0003_0000);
        rd(A_CNT_LO, r); chk("R4 pre-clear snapshot", r, 50);
        wr(A_CTRL, 32'h0002_0000);
        rd(A_CNT_LO, r); chk("R4 cleared", r, 0);

        // R5 limit match
        wr(A_IDX, 0);
        wr(A_CFG, cfg_word(0));
        wr(A_CNT_LO, 0);
        wr(A_LIM_LO, 3);
        wr(A_INTEN, 1);
        pulse(4'b0001, 2);
        rd(A_ACT, r);    chk("R5 before limit", r, 0);
        pulse(4'b0001, 1);
        rd(A_ACT, r);    chk("R5 at limit", r, 1);
        chk("R7 irq raised", 32'(irq_o), 1);
        pulse(4'b0001, 2);
        wr(A_CTRL, 32'h0002_0000);
        rd(A_CNT_LO, r); chk("R5 keeps counting", r, 5);

        // R6 disabled counter never flags
        wr(A_IDX, 2);
        wr(A_CFG, cfg_word(1));
        wr(A_CNT_LO, 0);
        wr(A_LIM_LO, 2);
        pulse(4'b0010, 3);
        rd(A_ACT, r);    chk("R6 no flag when disabled", r, 1);

        // R7 per-bit acknowledge
        wr(A_INTEN, 5);
        wr(A_CNT_LO, 0);
        pulse(4'b0010, 2);
        rd(A_ACT, r);    chk("R7 two flags", r, 5);
        wr(A_ACT, 1);
        rd(A_ACT, r);    chk("R7 one acked", r, 4);
        chk("R7 irq still high", 32'(irq_o), 1);
        wr(A_ACT, 4);
        rd(A_ACT, r);    chk("R7 all acked", r, 0);
        chk("R7 irq low", 32'(irq_o), 0);

        // R8 set beats clear on the same edge
        wr(A_IDX, 0);
        wr(A_CNT_LO, 10);
        wr(A_LIM_LO, 11);
        pulse(4'b0001, 1);
        rd(A_ACT, r);    chk("R8 flag set", r, 1);
        wr(A_CNT_LO, 20);
        wr(A_LIM_LO, 21);
        wr_ev(A_ACT, 1, 4'b0001);
        rd(A_ACT, r);    chk("R8 set wins", r, 1);
        wr(A_ACT, 1);
        rd(A_ACT, r);    chk("R8 later clear", r, 0);

        // R9 out-of-range index
        wr(A_IDX, 7);
        wr(A_LIM_LO, 32'h1234);
        wr(A_CFG, cfg_word(3));
        rd(A_LIM_LO, r); chk("R9 limit reads zero", r, 0);
        rd(A_CFG, r);    chk("R9 cfg reads zero", r, 0);
        rd(A_CNT_LO, r); chk("R9 count reads zero", r, 0);
        wr(A_IDX, 3);
        rd(A_LIM_LO, r); chk("R9 slot3 untouched", r, 0);
        rd(A_CFG, r);    chk("R9 slot3 cfg untouched", r, 0);

        // R2/R5 random runs
        for (int it = 0; it < 24; it++) begin
            int c, s, n, k, hits;
            c = int'($urandom % NC);
            s = int'($urandom % NE);
            n = 1 + int'($urandom % 40);
            k = 1 + int'($urandom % 40);
            start = {$urandom, $urandom};
            if (it % 4 == 0) start[31:0] = 32'hFFFF_FFF0 + ($urandom % 8);
            lim = start + 64'(k);
            wr(A_INTEN, 32'(1) << c);
            wr(A_ACT, 32'hF);
            wr(A_IDX, 32'(c));
            wr(A_CFG, cfg_word(s));
            wr(A_CNT_LO, start[31:0]);
            wr(A_CNT_HI, start[63:32]);
            wr(A_LIM_LO, lim[31:0]);
            wr(A_LIM_HI, lim[63:32]);
            hits = 0;
            for (int j = 0; j < n; j++) begin
                logic [NE-1:0] v;
                v = NE'($urandom);
                @(negedge clk);
                evt_in = v;
                if (v[s]) hits++;
            end
            @(negedge clk);
            evt_in = '0;
            expc = start + 64'(hits);
            wr(A_CTRL, 32'h0002_0000);
            rd(A_CNT_LO, r); chk("R2 random count low", r, expc[31:0]);
            rd(A_CNT_HI, r); chk("R2 random count high", r, expc[63:32]);
            rd(A_ACT, r);    chk("R5 random flag", r, (hits >= k) ? (32'(1) << c) : 32'(0));
            chk("R7 random irq", 32'(irq_o), (hits >= k) ? 32'(1) : 32'(0));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule